// File: doc/BRIEF.md
# Perfect-Hash Rule Number Lookup

This block turns a resolved prefix vector (one longest-match label per header field, concatenated into one key) into a rule number in constant time. Two independent XOR-matrix hashes of the whole key give two vertex addresses. The block reads one integer from a vertex table at each address and adds the two. The table contents are built offline, so that every prefix combination meant for a rule hashes to that rule's number. Collisions are intended: no key is stored and no compare is made.

The vertex table sits inside the block as two identical banks, one per hash, which are loaded through a shared write port. Both reads have a fixed two-cycle latency. A short context pipeline runs beside the reads and keeps each packet's valid flag, no-match flag and tag aligned with its returning data. The block accepts a new packet on every cycle. A packet flagged as matching nothing skips the reads and returns the default rule 0.

Top module: `rule_hash_lookup`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_rule` is 0.
- R2: Hash j (j = A, B) is an ADDR_W-bit address: the XOR of row i of matrix j over every key bit i that is 1. Row i is the low ADDR_W bits of mix(seed_j, i). The mix function is: x = seed ^ (i * 0x9E3779B1); x ^= x >> 15; x = x * 0x85EBCA6B; x ^= x >> 13. All arithmetic is 32-bit. The default seeds are 0x1234ABCD (A) and 0x5A5A0F0F (B).
- R3: For a packet without the no-match flag, `out_rule` = T[hashA] + T[hashB], where T is the loaded vertex table.
- R4: A packet sampled at clock edge n shows its result, with `out_valid` high, during the cycle after edge n+2. The latency is the same for every key and every table content.
- R5: Packets on consecutive cycles produce results on consecutive cycles, in order, and each carries its own `in_tag` on `out_tag`.
- R6: A packet with `in_nomatch` = 1 produces `out_valid` = 1 and `out_rule` = 0, whatever the table holds.
- R7: A write with `cfg_we` = 1 stores `cfg_data` at `cfg_addr` in both banks. Any packet sampled at or after the write edge sees the new value.
- R8: `out_valid` is 0 three cycles after any cycle in which `in_valid` was 0.
- R9: Two different keys give the same rule number when their vertex values sum to the same total.
- R10: The sum wraps modulo 2^RULE_W: two entries of 0xFFFF give 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet present this cycle |
| in_nomatch | input | 1 | Packet matches no rule; skip the table reads |
| in_key | input | KEY_W | Concatenated prefix-vector key |
| in_tag | input | TAG_W | Per-packet context carried to the output |
| cfg_we | input | 1 | Vertex table write enable |
| cfg_addr | input | ADDR_W | Vertex table write address |
| cfg_data | input | RULE_W | Vertex value to write |
| out_valid | output | 1 | Result present this cycle |
| out_rule | output | RULE_W | Rule number |
| out_tag | output | TAG_W | Tag of the packet whose result this is |

## Verification
The bench builds the block with its defaults: a 40-bit key, 10-bit addresses (a 1024-entry table), 16-bit rule numbers and 8-bit tags. With all 1024 entries loaded from a known pattern, every key the bench picks lands on real data. The 16-bit width lets the bench force a wrapping sum by writing 0xFFFF. The table size also lets the bench search for a second key whose four addresses are all distinct, so it can build an intended collision without disturbing the first key.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
   // Row generator for the XOR-matrix hashes
   function automatic logic [31:0] row_mix(input logic [31:0] seed, input int unsigned idx);
      logic [31:0] x;
      x = seed ^ (32'(idx) * 32'h9E3779B1);
      x = x ^ (x >> 15);
      x = x * 32'h85EBCA6B;
      x = x ^ (x >> 13);
      return x;
   endfunction
endpackage

// File: rtl/rhl_hash.sv
module rhl_hash #(
   parameter int unsigned KEY_W  = 40,
   parameter int unsigned ADDR_W = 10,
   parameter logic [31:0] SEED   = 32'h1234ABCD
) (
   input  logic [KEY_W-1:0]  key,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] term [KEY_W];

   for (genvar i = 0; i < KEY_W; i++) begin : g_row
      localparam logic [31:0] ROW = rhl_pkg::row_mix(SEED, i);
      assign term[i] = key[i] ? ROW[ADDR_W-1:0] : '0;
   end

   always_comb begin
      addr = '0;
      for (int i = 0; i < KEY_W; i++) addr = addr ^ term[i];
   end
endmodule

// File: rtl/rhl_vertex_ram.sv
module rhl_vertex_ram #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] raddr_q;
   logic              re_q;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      re_q <= re;
      if (re) raddr_q <= raddr;
      if (re_q) rdata <= mem[raddr_q];
   end
endmodule

// File: rtl/rhl_ctx_pipe.sv
module rhl_ctx_pipe #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned W     = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_ctx,
   output logic         out_vld,
   output logic [W-1:0] out_ctx
);
   logic         vld [DEPTH+1];
   logic [W-1:0] ctx [DEPTH+1];

   assign vld[0] = in_vld;
   assign ctx[0] = in_ctx;

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[s+1] <= 1'b0;
            ctx[s+1] <= '0;
         end else begin
            vld[s+1] <= vld[s];
            ctx[s+1] <= ctx[s];
         end
      end
   end

   assign out_vld = vld[DEPTH];
   assign out_ctx = ctx[DEPTH];
endmodule

// File: rtl/rule_hash_lookup.sv
module rule_hash_lookup #(
   parameter int unsigned KEY_W   = 40,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned RULE_W  = 16,
   parameter int unsigned TAG_W   = 8,
   parameter logic [31:0] SEED_A  = 32'h1234ABCD,
   parameter logic [31:0] SEED_B  = 32'h5A5A0F0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_nomatch,
   input  logic [KEY_W-1:0]  in_key,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [RULE_W-1:0] cfg_data,
   output logic              out_valid,
   output logic [RULE_W-1:0] out_rule,
   output logic [TAG_W-1:0]  out_tag
);
   localparam int unsigned RD_LAT = 2;
   localparam int unsigned CTX_W  = TAG_W + 1;
   localparam int unsigned N_BANK = 2;

   if (KEY_W < 1)                   begin : g_bad_key  $error("KEY_W must be at least 1");      end
   if (ADDR_W < 1 || ADDR_W > 16)   begin : g_bad_addr $error("ADDR_W must lie in 1..16");     end
   if (RULE_W < 1 || RULE_W > 32)   begin : g_bad_rule $error("RULE_W must lie in 1..32");     end
   if (TAG_W < 1)                   begin : g_bad_tag  $error("TAG_W must be at least 1");      end
   if (SEED_A == SEED_B)            begin : g_bad_seed $error("hash seeds must differ");        end

   logic [ADDR_W-1:0] vaddr [N_BANK];
   logic [RULE_W-1:0] vdata [N_BANK];
   logic              rd_en;

   assign rd_en = in_valid & ~in_nomatch;

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      localparam logic [31:0] SEED = (b == 0) ? SEED_A : SEED_B;
      rhl_hash #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .SEED(SEED)) u_hash (
         .key  (in_key),
         .addr (vaddr[b])
      );
      rhl_vertex_ram #(.ADDR_W(ADDR_W), .DATA_W(RULE_W)) u_ram (
         .clk   (clk),
         .we    (cfg_we),
         .waddr (cfg_addr),
         .wdata (cfg_data),
         .re    (rd_en),
         .raddr (vaddr[b]),
         .rdata (vdata[b])
      );
   end

   logic             ctx_vld;
   logic [CTX_W-1:0] ctx_q;

   rhl_ctx_pipe #(.DEPTH(RD_LAT), .W(CTX_W)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_valid),
      .in_ctx  ({in_nomatch, in_tag}),
      .out_vld (ctx_vld),
      .out_ctx (ctx_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rule  <= '0;
         out_tag   <= '0;
      end else begin
         out_valid <= ctx_vld;
         out_tag   <= ctx_q[TAG_W-1:0];
         if (ctx_vld) out_rule <= ctx_q[TAG_W] ? '0 : RULE_W'(vdata[0] + vdata[1]);
      end
   end
endmodule

// File: rtl/rule_hash_lookup_chk.sv
module rule_hash_lookup_chk #(
   parameter int unsigned RULE_W = 16,
   parameter int unsigned TAG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_nomatch,
   input logic [TAG_W-1:0]  in_tag,
   input logic              out_valid,
   input logic [RULE_W-1:0] out_rule,
   input logic [TAG_W-1:0]  out_tag
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 3) age <= age + 2'd1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_rule == '0)); // R1
   AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (age == 3 && $past(in_valid, 3))); // R4
   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3 && $past(in_valid, 3)) |-> out_valid); // R4
   AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3 && !$past(in_valid, 3)) |-> !out_valid); // R8
   AST_TAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_tag == $past(in_tag, 3)); // R5
   AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_nomatch, 3)) |-> out_rule == '0); // R6
endmodule

bind rule_hash_lookup rule_hash_lookup_chk #(.RULE_W(RULE_W), .TAG_W(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_nomatch (in_nomatch),
   .in_tag     (in_tag),
   .out_valid  (out_valid),
   .out_rule   (out_rule),
   .out_tag    (out_tag)
);

// File: tb/rule_hash_lookup_tb.sv
`timescale 1ns/1ps
module rule_hash_lookup_tb;
   localparam int unsigned KEY_W  = 40;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned RULE_W = 16;
   localparam int unsigned TAG_W  = 8;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam logic [31:0] SA = 32'h1234ABCD;
   localparam logic [31:0] SB = 32'h5A5A0F0F;
   localparam int NV = 10;
   // {nomatch, tag, key}
   localparam logic [KEY_W+TAG_W:0] VEC [NV] = '{
      {1'b0, 8'h01, 40'h00_0000_0000},
      {1'b0, 8'h02, 40'h00_0000_0001},
      {1'b0, 8'h03, 40'h80_0000_0000},
      {1'b1, 8'h04, 40'hC0_A8_01_02_11},
      {1'b0, 8'h05, 40'hFF_FF_FF_FF_FF},
      {1'b0, 8'h06, 40'h0A_00_00_01_06},
      {1'b0, 8'h07, 40'h12_34_56_78_9A},
      {1'b1, 8'h08, 40'h00_0000_0000},
      {1'b0, 8'h09, 40'hA5_A5_5A_5A_33},
      {1'b0, 8'h0A, 40'h0F_0F_F0_F0_C3}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0, in_nomatch = 1'b0;
   logic [KEY_W-1:0]  in_key = '0;
   logic [TAG_W-1:0]  in_tag = '0;
   logic              cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [RULE_W-1:0] cfg_data = '0;
   logic              out_valid;
   logic [RULE_W-1:0] out_rule;
   logic [TAG_W-1:0]  out_tag;

   int checks = 0, errors = 0, cyc = 0;
   logic [RULE_W-1:0] tbl [DEPTH];

   always #2 clk = ~clk;

   rule_hash_lookup u_dut (.*);

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] hsh(input logic [31:0] seed, input logic [KEY_W-1:0] k);
      logic [ADDR_W-1:0] a = '0;
      for (int i = 0; i < KEY_W; i++) begin
         logic [31:0] x;
         x = seed ^ (32'(i) * 32'h9E3779B1);
         x = x ^ (x >> 15);
         x = x * 32'h85EBCA6B;
         x = x ^ (x >> 13);
         if (k[i]) a = a ^ x[ADDR_W-1:0];
      end
      return a;
   endfunction

   function automatic logic [RULE_W-1:0] model(input logic nm, input logic [KEY_W-1:0] k);
      if (nm) return '0;
      return tbl[hsh(SA, k)] + tbl[hsh(SB, k)];
   endfunction

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [RULE_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
      tbl[a] = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // one packet, result read three negedges after driving (R4)
   task automatic one(input logic nm, input logic [KEY_W-1:0] k, input logic [TAG_W-1:0] t,
                      output logic v, output logic [RULE_W-1:0] r);
      @(negedge clk);
      in_valid = 1'b1; in_nomatch = nm; in_key = k; in_tag = t;
      @(negedge clk);
      in_valid = 1'b0; in_nomatch = 1'b0;
      @(negedge clk);
      @(negedge clk);
      v = out_valid; r = out_rule;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic v;
      logic [RULE_W-1:0] r, ra;
      logic [KEY_W-1:0] ka, kb;
      logic [ADDR_W-1:0] a1, a2, b1, b2;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", out_valid, 0);
      chk("R1 rule in reset", out_rule, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after release", out_valid, 0);

      // load every entry (R7)
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_addr = ADDR_W'(a);
         cfg_data = RULE_W'(a * 40503 + 16'h1357);
         tbl[a] = cfg_data;
      end
      @(negedge clk);
      cfg_we = 1'b0;

      // table walk, back to back (R2 R3 R4 R5 R6)
      for (int i = 0; i < NV + 3; i++) begin
         @(negedge clk);
         if (i >= 3) begin
            chk("R4 R5 valid stream", out_valid, 1);
            chk("R5 tag order", out_tag, VEC[i-3][KEY_W+TAG_W-1:KEY_W]);
            chk(VEC[i-3][KEY_W+TAG_W] ? "R6 nomatch rule" : "R2 R3 rule",
                out_rule, model(VEC[i-3][KEY_W+TAG_W], VEC[i-3][KEY_W-1:0]));
         end
         if (i < NV) begin
            in_valid = 1'b1; in_nomatch = VEC[i][KEY_W+TAG_W];
            in_tag = VEC[i][KEY_W+TAG_W-1:KEY_W]; in_key = VEC[i][KEY_W-1:0];
         end else begin
            in_valid = 1'b0; in_nomatch = 1'b0;
         end
      end
      // R8: idle input yields no output
      @(negedge clk);
      chk("R8 idle", out_valid, 0);

      // R10: wraparound
      ka = 40'h33_44_55_66_77;
      a1 = hsh(SA, ka); a2 = hsh(SB, ka);
      wr(a1, 16'hFFFF);
      wr(a2, 16'hFFFF);
      one(1'b0, ka, 8'hE1, v, r);
      chk("R10 wrap", r, 16'hFFFE);

      // R7: rewrite one entry, packet sees new value
      wr(a1, 16'h0100);
      one(1'b0, ka, 8'hE2, v, r);
      chk("R7 rewrite", r, RULE_W'(16'h0100 + tbl[a2]));

      // R6: nomatch ignores the table
      one(1'b1, ka, 8'hE3, v, r);
      chk("R6 valid", v, 1);
      chk("R6 rule zero", r, 0);

      // R9: build an intended collision
      ka = 40'h01_02_03_04_05;
      a1 = hsh(SA, ka); a2 = hsh(SB, ka);
      ra = model(1'b0, ka);
      kb = 40'h10_00_00_00_00;
      for (int n = 0; n < 200; n++) begin
         b1 = hsh(SA, kb); b2 = hsh(SB, kb);
         if (b1 != b2 && b1 != a1 && b1 != a2 && b2 != a1 && b2 != a2) break;
         kb = kb + 40'h1_0000_0007;
      end
      wr(b1, RULE_W'(ra - tbl[b2]));
      one(1'b0, kb, 8'hE4, v, r);
      chk("R9 second key", r, ra);
      one(1'b0, ka, 8'hE5, v, r);
      chk("R9 first key", r, ra);

      // R1: reset mid-stream clears output
      @(negedge clk);
      in_valid = 1'b1; in_key = ka; in_tag = 8'hE6;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset valid", out_valid, 0);
      chk("R1 mid reset rule", out_rule, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 R8 no stale output", out_valid, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule